// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage Pipeline

This block follows every instruction of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) together with a small exception record. Each stage that can detect a fault marks the instruction it holds with a 3-bit cause code. The code then travels with that instruction through the stage registers. An instruction that is already marked keeps its first cause, whatever the later stages report.

Faults are taken at one point only: the boundary between memory and writeback. Instructions reach that point in program order, so the oldest faulting instruction always wins. This holds even when a younger instruction was flagged earlier in its own life. When the instruction in the memory stage carries a cause, the block does four things in that same cycle. It raises a trap, redirects fetch to a fixed vector, and squashes every younger instruction. It also keeps the faulting instruction from writing memory or the register file. The faulting PC and its cause are latched for the handler.

The surrounding pipeline drives the per-stage valid bit and PC into fetch and the fault strobes of each stage. It uses the flush, store-permission and writeback-permission outputs to gate its own state updates.

Top module: `exc_tracker`

## Requirements
- R1: A synchronous active-low reset empties all three tracked stage registers and clears the writeback permission and the latched PC and cause (cause 0). While the pipeline is empty, no trap is raised.
- R2: A fetch fault marks the instruction with cause 1 (instruction page fault) or cause 2 (instruction misaligned). When both strobes are high in the same cycle, cause 1 is recorded.
- R3: A decode fault marks the instruction with cause 3 (illegal opcode). An execute fault marks it with cause 4 (arithmetic overflow).
- R4: A memory-stage fault marks the instruction with cause 5 (data page fault) or cause 6 (data misaligned). When both strobes are high in the same cycle, cause 5 is recorded.
- R5: A fault strobe for a stage whose valid bit is low has no effect.
- R6: An instruction that already carries a nonzero cause keeps it unchanged. Strobes raised against it in later stages are ignored.
- R7: The trap output is high exactly in the cycle a valid, marked instruction sits in the memory stage. In that cycle the redirect target equals the TRAP_VEC parameter and the flush output is high. An older instruction's later fault is therefore taken before a younger instruction's earlier fault.
- R8: On a trap, the instructions then in fetch, decode and execute are squashed. None of them ever reaches the memory stage, traps, or gets writeback permission.
- R9: The faulting PC and cause appear on the latched outputs in the cycle after the trap. They hold until the next trap.
- R10: A marked instruction in the memory stage has its store permission low and never receives writeback permission. An unmarked valid one has store permission high.
- R11: An unmarked instruction presented to fetch in cycle t is in the memory stage in cycle t+3 and has writeback permission in cycle t+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_valid | input | 1 | Fetch stage holds an instruction |
| if_pc | input | PC_W | PC of the fetched instruction |
| if_page_fault | input | 1 | Instruction page fault in fetch |
| if_misalign | input | 1 | Misaligned instruction fetch |
| id_illegal | input | 1 | Decode found an undefined opcode |
| ex_overflow | input | 1 | Execute raised an arithmetic overflow |
| mem_page_fault | input | 1 | Data page fault in memory stage |
| mem_misalign | input | 1 | Misaligned data access in memory stage |
| trap_take | output | 1 | Exception taken this cycle |
| trap_target | output | PC_W | Redirect PC (TRAP_VEC during a trap, else 0) |
| flush_younger | output | 1 | Squash fetch, decode and execute this cycle |
| mem_store_ok | output | 1 | Memory-stage instruction may write memory |
| wb_write_ok | output | 1 | Writeback-stage instruction may write the register file |
| exc_pc | output | PC_W | Latched PC of the last faulting instruction |
| exc_cause | output | 3 | Latched cause of the last fault |

## Verification
The bench builds the block with PC_W = 16 and TRAP_VEC = 16'h0080. This keeps the PCs and the vector short enough to write the expected value of every cycle into the vector table by hand. The run includes a sequence where an older instruction overflows in execute while a younger one faults in fetch and decode. Each squashed slot is checked as it passes the memory stage. A second reset, applied after several traps, shows that the latched record is cleared.

// File: rtl/exc_trk_pkg.sv
// Package: cause encoding and per-stage cause encoders shared by the tracker.
// Assumes at most one record per stage; a cause of zero means "no fault".
package exc_trk_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE      = 3'd0,
        CAUSE_IFETCH_PF = 3'd1,
        CAUSE_IFETCH_MA = 3'd2,
        CAUSE_ILLEGAL   = 3'd3,
        CAUSE_OVERFLOW  = 3'd4,
        CAUSE_DATA_PF   = 3'd5,
        CAUSE_DATA_MA   = 3'd6
    } cause_e;

    // Stage registers between fetch/decode, decode/execute, execute/memory.
    localparam int NUM_SLOTS = 3;

    // Fetch encoder: page fault takes precedence over misalignment.
    function automatic cause_e fetch_cause(input logic pf, input logic ma);
        if (pf)      return CAUSE_IFETCH_PF;
        else if (ma) return CAUSE_IFETCH_MA;
        else         return CAUSE_NONE;
    endfunction

    // Memory encoder: page fault takes precedence over misalignment.
    function automatic cause_e data_cause(input logic pf, input logic ma);
        if (pf)      return CAUSE_DATA_PF;
        else if (ma) return CAUSE_DATA_MA;
        else         return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/exc_trk_slot.sv
// One pipeline register of the exception record (valid, PC, cause).
// Merges the stage's own fault into an unmarked instruction and keeps an
// existing cause untouched. Assumes the pipeline advances every cycle.
module exc_trk_slot
    import exc_trk_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            squash,
    input  logic            in_valid,
    input  logic [PC_W-1:0] in_pc,
    input  cause_e          in_cause,
    input  cause_e          local_cause,
    output logic            out_valid,
    output logic [PC_W-1:0] out_pc,
    output cause_e          out_cause
);

    cause_e merged;

    // First cause wins; an empty slot carries no cause.
    always_comb begin
        if (!in_valid)                merged = CAUSE_NONE;
        else if (in_cause != CAUSE_NONE) merged = in_cause;
        else                          merged = local_cause;
    end

    // Advance the record one stage, dropping it when squashed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pc    <= '0;
            out_cause <= CAUSE_NONE;
        end else begin
            out_valid <= in_valid & ~squash;
            out_pc    <= in_pc;
            out_cause <= merged;
        end
    end

    a_r8_squash_kills: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> !out_valid);

    a_r5_empty_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r6_cause_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cause != CAUSE_NONE && !squash) |=> out_cause == $past(in_cause));

endmodule

// File: rtl/exc_trk_commit.sv
// Commit point at the memory/writeback boundary. Decides whether the
// instruction in the memory stage traps, gates its side effects, holds the
// writeback valid bit and latches the faulting PC and cause.
// Assumes the record arriving here is already in program order.
module exc_trk_commit
    import exc_trk_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mem_valid,
    input  logic [PC_W-1:0] mem_pc,
    input  cause_e          mem_cause,
    input  cause_e          local_cause,
    output logic            trap,
    output logic            store_ok,
    output logic            wb_valid,
    output logic [PC_W-1:0] exc_pc,
    output cause_e          exc_cause
);

    cause_e final_cause;

    // Final cause of the memory-stage instruction and the trap decision.
    always_comb begin
        final_cause = (mem_cause != CAUSE_NONE) ? mem_cause : local_cause;
        trap        = mem_valid && (final_cause != CAUSE_NONE);
        store_ok    = mem_valid && !trap;
    end

    // Retire clean instructions into writeback; latch the record on a trap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid  <= 1'b0;
            exc_pc    <= '0;
            exc_cause <= CAUSE_NONE;
        end else begin
            wb_valid <= mem_valid & ~trap;
            if (trap) begin
                exc_pc    <= mem_pc;
                exc_cause <= final_cause;
            end
        end
    end

    a_r10_faulty_not_written: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> !wb_valid);

    a_r9_pc_latched: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> exc_pc == $past(mem_pc));

    a_r9_record_held: assert property (@(posedge clk) disable iff (!rst_n)
        !trap |=> ($stable(exc_pc) && $stable(exc_cause)));

    a_r6_carried_cause_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_cause != CAUSE_NONE) |-> trap);

endmodule

// File: rtl/exc_tracker.sv
// Top: carries an exception record beside each instruction of a five-stage
// pipeline and raises faults precisely, oldest first, at the memory/writeback
// boundary. Assumes the pipeline advances one stage per cycle.
module exc_tracker
    import exc_trk_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] TRAP_VEC = 'h100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            if_valid,
    input  logic [PC_W-1:0] if_pc,
    input  logic            if_page_fault,
    input  logic            if_misalign,
    input  logic            id_illegal,
    input  logic            ex_overflow,
    input  logic            mem_page_fault,
    input  logic            mem_misalign,
    output logic            trap_take,
    output logic [PC_W-1:0] trap_target,
    output logic            flush_younger,
    output logic            mem_store_ok,
    output logic            wb_write_ok,
    output logic [PC_W-1:0] exc_pc,
    output logic [2:0]      exc_cause
);

    logic            slot_valid [NUM_SLOTS+1];
    logic [PC_W-1:0] slot_pc    [NUM_SLOTS+1];
    cause_e          slot_cause [NUM_SLOTS+1];
    cause_e          stage_cause[NUM_SLOTS];
    cause_e          mem_local;
    cause_e          exc_cause_e;
    logic            trap;

    // Per-stage fault encoders, in stage order.
    always_comb begin
        stage_cause[0] = fetch_cause(if_page_fault, if_misalign);
        stage_cause[1] = id_illegal  ? CAUSE_ILLEGAL  : CAUSE_NONE;
        stage_cause[2] = ex_overflow ? CAUSE_OVERFLOW : CAUSE_NONE;
        mem_local      = data_cause(mem_page_fault, mem_misalign);
    end

    // Fetch enters the chain without a carried cause.
    always_comb begin
        slot_valid[0] = if_valid;
        slot_pc[0]    = if_pc;
        slot_cause[0] = CAUSE_NONE;
    end

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        exc_trk_slot #(.PC_W(PC_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .squash     (trap),
            .in_valid   (slot_valid[k]),
            .in_pc      (slot_pc[k]),
            .in_cause   (slot_cause[k]),
            .local_cause(stage_cause[k]),
            .out_valid  (slot_valid[k+1]),
            .out_pc     (slot_pc[k+1]),
            .out_cause  (slot_cause[k+1])
        );
    end

    exc_trk_commit #(.PC_W(PC_W)) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_valid  (slot_valid[NUM_SLOTS]),
        .mem_pc     (slot_pc[NUM_SLOTS]),
        .mem_cause  (slot_cause[NUM_SLOTS]),
        .local_cause(mem_local),
        .trap       (trap),
        .store_ok   (mem_store_ok),
        .wb_valid   (wb_write_ok),
        .exc_pc     (exc_pc),
        .exc_cause  (exc_cause_e)
    );

    // Redirect and flush controls follow the commit decision.
    always_comb begin
        trap_take     = trap;
        flush_younger = trap;
        trap_target   = trap ? TRAP_VEC : '0;
        exc_cause     = exc_cause_e;
    end

    a_r11_clean_retires: assert property (@(posedge clk) disable iff (!rst_n)
        mem_store_ok |=> wb_write_ok);

    a_r7_trap_needs_record: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |-> slot_valid[NUM_SLOTS]);

endmodule

// File: tb/exc_tracker_bench.sv
// Bench: per-cycle vector table walked by one loop, then directed reset checks.
module exc_tracker_bench;

    localparam int              PC_W = 16;
    localparam logic [15:0]     VEC  = 16'h0080;
    localparam int              NV   = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        if_valid = 1'b0;
    logic [15:0] if_pc = '0;
    logic        if_page_fault = 1'b0, if_misalign = 1'b0, id_illegal = 1'b0;
    logic        ex_overflow = 1'b0, mem_page_fault = 1'b0, mem_misalign = 1'b0;
    logic        trap_take, flush_younger, mem_store_ok, wb_write_ok;
    logic [15:0] trap_target, exc_pc;
    logic [2:0]  exc_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    exc_tracker #(.PC_W(PC_W), .TRAP_VEC(VEC)) u_exc_tracker (
        .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_pc(if_pc),
        .if_page_fault(if_page_fault), .if_misalign(if_misalign),
        .id_illegal(id_illegal), .ex_overflow(ex_overflow),
        .mem_page_fault(mem_page_fault), .mem_misalign(mem_misalign),
        .trap_take(trap_take), .trap_target(trap_target),
        .flush_younger(flush_younger), .mem_store_ok(mem_store_ok),
        .wb_write_ok(wb_write_ok), .exc_pc(exc_pc), .exc_cause(exc_cause)
    );

    // {ifv, pc[16], ifpf, ifma, idill, exovf, mpf, mma, trap, store, wb, cause[3], epc[16]}
    localparam logic [44:0] VT [NV] = '{
        {1'b1,16'h0100,6'b000000,3'b000,3'd0,16'h0000}, // 0  A fetched
        {1'b1,16'h0104,6'b000000,3'b000,3'd0,16'h0000}, // 1  B
        {1'b1,16'h0108,6'b000000,3'b000,3'd0,16'h0000}, // 2  C
        {1'b1,16'h010C,6'b000000,3'b010,3'd0,16'h0000}, // 3  A in mem R11
        {1'b1,16'h0110,6'b110000,3'b011,3'd0,16'h0000}, // 4  E both fetch faults R2
        {1'b0,16'h0000,6'b100000,3'b011,3'd0,16'h0000}, // 5  idle fetch fault R5
        {1'b0,16'h0000,6'b001100,3'b011,3'd0,16'h0000}, // 6  idle decode R5, E ovf ignored R6
        {1'b0,16'h0000,6'b000010,3'b101,3'd0,16'h0000}, // 7  E traps R7 R10
        {1'b0,16'h0000,6'b000000,3'b000,3'd1,16'h0110}, // 8  record R9 R2
        {1'b1,16'h0120,6'b000000,3'b000,3'd1,16'h0110}, // 9  F
        {1'b1,16'h0124,6'b010000,3'b000,3'd1,16'h0110}, // 10 G misaligned fetch
        {1'b1,16'h0128,6'b001100,3'b000,3'd1,16'h0110}, // 11 H; F ovf R3, G illegal ignored R6
        {1'b1,16'h012C,6'b000000,3'b100,3'd1,16'h0110}, // 12 F traps, older wins R7
        {1'b1,16'h0130,6'b000010,3'b000,3'd4,16'h0120}, // 13 G squashed R8
        {1'b0,16'h0000,6'b000000,3'b000,3'd4,16'h0120}, // 14 H squashed R8
        {1'b0,16'h0000,6'b000000,3'b000,3'd4,16'h0120}, // 15 I squashed R8
        {1'b0,16'h0000,6'b000000,3'b010,3'd4,16'h0120}, // 16 J in mem
        {1'b0,16'h0000,6'b000000,3'b001,3'd4,16'h0120}, // 17 J written
        {1'b1,16'h0140,6'b000000,3'b000,3'd4,16'h0120}, // 18 K
        {1'b0,16'h0000,6'b000000,3'b000,3'd4,16'h0120}, // 19
        {1'b0,16'h0000,6'b000000,3'b000,3'd4,16'h0120}, // 20
        {1'b0,16'h0000,6'b000001,3'b100,3'd4,16'h0120}, // 21 K data misaligned R4
        {1'b1,16'h0150,6'b000000,3'b000,3'd6,16'h0140}, // 22 L
        {1'b1,16'h0154,6'b000000,3'b000,3'd6,16'h0140}, // 23 M
        {1'b0,16'h0000,6'b001000,3'b000,3'd6,16'h0140}, // 24 M illegal
        {1'b0,16'h0000,6'b000011,3'b100,3'd6,16'h0140}, // 25 L both data faults R4
        {1'b0,16'h0000,6'b000000,3'b000,3'd5,16'h0150}, // 26 M squashed R8
        {1'b1,16'h0160,6'b000000,3'b000,3'd5,16'h0150}, // 27 N
        {1'b0,16'h0000,6'b001000,3'b000,3'd5,16'h0150}, // 28 N illegal R3
        {1'b0,16'h0000,6'b000000,3'b000,3'd5,16'h0150}, // 29
        {1'b0,16'h0000,6'b000000,3'b100,3'd5,16'h0150}, // 30 N traps
        {1'b0,16'h0000,6'b000000,3'b000,3'd3,16'h0160}  // 31 cause 3 latched R3
    };

    task automatic check(input string req, input int row, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s row %0d: actual %h expected %h", req, row, act, exp);
        end
    endtask

    task automatic drive_idle();
        if_valid = 1'b0; if_pc = '0;
        {if_page_fault, if_misalign, id_illegal, ex_overflow,
         mem_page_fault, mem_misalign} = 6'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        drive_idle();
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        // R1: state after reset
        check("R1 trap", -1, 16'(trap_take), 16'h0);
        check("R1 store", -1, 16'(mem_store_ok), 16'h0);
        check("R1 wb", -1, 16'(wb_write_ok), 16'h0);
        check("R1 cause", -1, 16'(exc_cause), 16'h0);
        check("R1 epc", -1, exc_pc, 16'h0);
        rst_n = 1'b1;

        // Vector table walk: drive after falling edge, sample before rising edge.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if_valid       = VT[i][44];
            if_pc          = VT[i][43:28];
            if_page_fault  = VT[i][27];
            if_misalign    = VT[i][26];
            id_illegal     = VT[i][25];
            ex_overflow    = VT[i][24];
            mem_page_fault = VT[i][23];
            mem_misalign   = VT[i][22];
            #3;
            check("R7 trap", i, 16'(trap_take), 16'(VT[i][21]));
            check("R7 flush", i, 16'(flush_younger), 16'(VT[i][21]));
            check("R7 target", i, trap_target, VT[i][21] ? VEC : 16'h0);
            check("R10 store", i, 16'(mem_store_ok), 16'(VT[i][20]));
            check("R11 wb", i, 16'(wb_write_ok), 16'(VT[i][19]));
            check("R9 cause", i, 16'(exc_cause), 16'(VT[i][18:16]));
            check("R9 epc", i, exc_pc, VT[i][15:0]);
        end

        // R1: reset in mid-flight clears the record and the pipeline.
        @(negedge clk);
        if_valid = 1'b1; if_pc = 16'h0200; ex_overflow = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0; drive_idle();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 cause after reset", -2, 16'(exc_cause), 16'h0);
        check("R1 epc after reset", -2, exc_pc, 16'h0);
        for (int j = 0; j < 4; j++) begin
            @(negedge clk); #3;
            check("R1 no trap after reset", j, 16'(trap_take), 16'h0);
            check("R1 no wb after reset", j, 16'(wb_write_ok), 16'h0);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule